// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends asynchronous serial frames on a single output line. Software places a data word into a holding buffer. The engine moves the word into a shift register when the line is free, transmit is enabled and the peer is ready. It then sends the frame: a low start bit, the data bits least significant first, an optional parity bit, and one or two high stop bits. Because the buffer and the shift register are separate, the next word can be written while the current frame is still on the line, so frames can follow each other with no idle gap.

The bit rate comes from a programmable divider. The divider counts ticks from a selectable source: the system clock divided by 2, 16, 64 or 512, or the rising edges of an external clock pin. A frame boundary is reached at the bit tick that ends the last stop bit, and also at every bit tick while the line is idle. Start conditions are checked only at a frame boundary. A flag shows that the holding buffer is empty, a second flag shows that the shift register is empty, and a sticky request bit tells the processor that a word was taken from the buffer.

Top module: `sertx_dbuf`

## Requirements
- R1: One bit lasts 16·(n+1) ticks of the selected source, where n is `div_i`. With the divide-by-2 source this is 32·(n+1) clock cycles.
- R2: `src_sel_i` selects the tick source: 0 is clock/2, 1 is clock/16, 2 is clock/64, 3 is clock/512, and 4 is a rising edge of `ext_clk_i` after a two-flop synchroniser.
- R3: A frame is one low start bit, then 8 data bits (`len9_i`=0) or 9 data bits (`len9_i`=1) with bit 0 first, then a parity bit if `par_en_i`=1, then one high stop bit (`stop2_i`=0) or two (`stop2_i`=1). The parity bit is the XOR of the data bits sent when `par_odd_i`=0, and its complement when `par_odd_i`=1.
- R4: After reset, `txd_o`=1, `buf_empty_o`=1, `reg_empty_o`=1 and `irq_o`=0.
- R5: A write pulse on `wr_i` makes `buf_empty_o` 0 on the next cycle. A second write while the buffer is full replaces the held word.
- R6: When a frame starts, the held word moves into the shift register. On the same clock edge that drives the start bit, `buf_empty_o` goes to 1 and `irq_o` goes to 1.
- R7: If the buffer holds a word when the last stop bit ends, and the other start conditions hold, the next start bit follows at once with no idle bit between the frames.
- R8: If `tx_en_i` is low at a frame boundary, no frame starts. A frame already in progress runs to its end. A held word stays in the buffer and `buf_empty_o` stays 0.
- R9: When `cts_sel_i`=1, a frame starts only while the synchronised `cts_n_i` is low. When `cts_sel_i`=0, `cts_n_i` has no effect.
- R10: `irq_o` stays 1 until `irq_ack_i` or `irq_clr_i` is high on a clock edge. Setting the bit takes priority over clearing it in the same cycle.
- R11: `reg_empty_o` is 0 from the start bit until the end of the last stop bit, and goes to 1 at that point if no new frame starts. While it is 1, `txd_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk_i | input | 1 | External tick source, asynchronous |
| src_sel_i | input | 3 | Tick source select (0..4) |
| div_i | input | 8 | Bit-rate divider setting n |
| tx_en_i | input | 1 | Transmit enable |
| len9_i | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even |
| stop2_i | input | 1 | 1 selects two stop bits |
| cts_sel_i | input | 1 | Enable gating of frame starts by the clear-to-send input |
| cts_n_i | input | 1 | Clear-to-send, active low, asynchronous |
| wr_i | input | 1 | Write pulse for the holding buffer |
| wr_data_i | input | 9 | Data word to write |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears the request |
| irq_clr_i | input | 1 | Software clear of the request |
| txd_o | output | 1 | Serial data line, idles high |
| buf_empty_o | output | 1 | Holding buffer empty |
| reg_empty_o | output | 1 | Shift register empty, line idle |
| irq_o | output | 1 | Sticky transmit interrupt request |

## Verification
The bench first targets the join between frames. A word written during a frame must start exactly when the last stop bit ends. A design that checks start conditions too late leaves an idle bit between the frames, and a design that checks them too early cuts the stop bit short. It then clears the enable, or holds clear-to-send high, while a word sits in the buffer. A design that ignores either input at the boundary puts an extra frame on the line. Random frame formats cover the parity polarity and the 9-bit, parity-on and two-stop-bit layouts, where a wrong bit count shifts every later bit by one. The slow prescaler taps and the external clock path are each run with real frames, so a wrong tap changes the measured bit time.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int DATA_W  = 9;
  localparam int FRAME_W = 1 + DATA_W + 1 + 2;
  localparam int LEN_W   = $clog2(FRAME_W + 1);
  localparam int NUM_PRE = 4;

  typedef enum logic [2:0] {
    SRC_DIV2   = 3'd0,
    SRC_DIV16  = 3'd1,
    SRC_DIV64  = 3'd2,
    SRC_DIV512 = 3'd3,
    SRC_EXT    = 3'd4
  } src_sel_e;

  typedef struct packed {
    logic [FRAME_W-1:0] bits;  // bit 0 goes on the line first
    logic [LEN_W-1:0]   len;   // number of bit times in the frame
  } frame_t;

  // log2 of the prescaler ratio for each tap
  function automatic int pre_log2(input int idx);
    case (idx)
      0:       return 1;
      1:       return 4;
      2:       return 6;
      default: return 9;
    endcase
  endfunction

  function automatic frame_t build_frame(
    input logic [DATA_W-1:0] d,
    input logic              len9,
    input logic              par_en,
    input logic              par_odd,
    input logic              stop2
  );
    frame_t           f;
    logic [LEN_W-1:0] pos;
    logic             pbit;
    f.bits      = '1;
    f.bits[0]   = 1'b0;
    f.bits[8:1] = d[7:0];
    pos         = LEN_W'(9);
    pbit        = ^d[7:0];
    if (len9) begin
      f.bits[9] = d[8];
      pbit      = pbit ^ d[8];
      pos       = LEN_W'(10);
    end
    if (par_en) begin
      f.bits[pos] = pbit ^ par_odd;
      pos         = pos + LEN_W'(1);
    end
    f.len = pos + (stop2 ? LEN_W'(2) : LEN_W'(1));
    return f;
  endfunction

endpackage

// File: rtl/sertx_baudgen.sv
module sertx_baudgen
  import sertx_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int OVS   = 16,
  parameter int PRE_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       src_sel,
  input  logic             ext_clk,
  input  logic [DIV_W-1:0] div,
  output logic             bit_tick
);

  localparam int OVS_W = $clog2(OVS);

  logic [PRE_W-1:0]   pre_cnt;
  logic [NUM_PRE-1:0] pre_tick;
  logic [2:0]         ext_sync;
  logic               ext_tick;
  logic               src_tick;
  logic [DIV_W-1:0]   div_cnt;
  logic [OVS_W-1:0]   ovs_cnt;

  always_ff @(posedge clk) begin
    if (rst) pre_cnt <= '0;
    else     pre_cnt <= pre_cnt + PRE_W'(1);
  end

  // one tap per prescaler ratio: a pulse once every 2**LG clocks
  for (genvar g = 0; g < NUM_PRE; g++) begin : g_tap
    localparam int LG = pre_log2(g);
    assign pre_tick[g] = &pre_cnt[LG-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) ext_sync <= '0;
    else     ext_sync <= {ext_sync[1:0], ext_clk};
  end
  assign ext_tick = ext_sync[1] & ~ext_sync[2];

  always_comb begin
    case (src_sel_e'(src_sel))
      SRC_DIV2:   src_tick = pre_tick[0];
      SRC_DIV16:  src_tick = pre_tick[1];
      SRC_DIV64:  src_tick = pre_tick[2];
      SRC_DIV512: src_tick = pre_tick[3];
      SRC_EXT:    src_tick = ext_tick;
      default:    src_tick = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt  <= '0;
      ovs_cnt  <= '0;
      bit_tick <= 1'b0;
    end else begin
      bit_tick <= 1'b0;
      if (src_tick) begin
        if (div_cnt >= div) begin
          div_cnt <= '0;
          if (ovs_cnt == OVS_W'(OVS - 1)) begin
            ovs_cnt  <= '0;
            bit_tick <= 1'b1;
          end else begin
            ovs_cnt <= ovs_cnt + OVS_W'(1);
          end
        end else begin
          div_cnt <= div_cnt + DIV_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/sertx_txbuf.sv
module sertx_txbuf
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load,
  input  logic              irq_ack,
  input  logic              irq_clr,
  output logic [DATA_W-1:0] held,
  output logic              empty,
  output logic              irq
);

  always_ff @(posedge clk) begin
    if (rst) begin
      held  <= '0;
      empty <= 1'b1;
    end else if (wr) begin
      held  <= wr_data;
      empty <= 1'b0;
    end else if (load) begin
      empty <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     irq <= 1'b0;
    else if (load)               irq <= 1'b1;
    else if (irq_ack || irq_clr) irq <= 1'b0;
  end

endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
  import sertx_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   bit_tick,
  input  logic   start_ok,
  input  frame_t frm,
  output logic   load,
  output logic   txd,
  output logic   reg_empty
);

  logic [FRAME_W-2:0] sr;
  logic [LEN_W-1:0]   remain;
  logic               at_boundary;

  assign at_boundary = (remain == '0);
  assign load        = bit_tick & at_boundary & start_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      txd       <= 1'b1;
      sr        <= '1;
      remain    <= '0;
      reg_empty <= 1'b1;
    end else if (bit_tick) begin
      if (!at_boundary) begin
        txd    <= sr[0];
        sr     <= {1'b1, sr[FRAME_W-2:1]};
        remain <= remain - LEN_W'(1);
      end else if (start_ok) begin
        txd       <= frm.bits[0];
        sr        <= frm.bits[FRAME_W-1:1];
        remain    <= frm.len - LEN_W'(1);
        reg_empty <= 1'b0;
      end else begin
        txd       <= 1'b1;
        reg_empty <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sertx_dbuf.sv
module sertx_dbuf
  import sertx_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int OVS   = 16,
  parameter int PRE_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_clk_i,
  input  logic [2:0]       src_sel_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             tx_en_i,
  input  logic             len9_i,
  input  logic             par_en_i,
  input  logic             par_odd_i,
  input  logic             stop2_i,
  input  logic             cts_sel_i,
  input  logic             cts_n_i,
  input  logic             wr_i,
  input  logic [8:0]       wr_data_i,
  input  logic             irq_ack_i,
  input  logic             irq_clr_i,
  output logic             txd_o,
  output logic             buf_empty_o,
  output logic             reg_empty_o,
  output logic             irq_o
);

  logic              bit_tick;
  logic [1:0]        cts_sync;
  logic              cts_ok;
  logic              start_ok;
  logic              load;
  logic [DATA_W-1:0] held;
  frame_t            frm;

  sertx_baudgen #(.DIV_W(DIV_W), .OVS(OVS), .PRE_W(PRE_W)) u_baud (
    .clk      (clk),
    .rst      (rst),
    .src_sel  (src_sel_i),
    .ext_clk  (ext_clk_i),
    .div      (div_i),
    .bit_tick (bit_tick)
  );

  always_ff @(posedge clk) begin
    if (rst) cts_sync <= 2'b11;
    else     cts_sync <= {cts_sync[0], cts_n_i};
  end

  assign cts_ok   = ~cts_sel_i | ~cts_sync[1];
  assign start_ok = tx_en_i & ~buf_empty_o & cts_ok;
  assign frm      = build_frame(held, len9_i, par_en_i, par_odd_i, stop2_i);

  sertx_txbuf u_buf (
    .clk     (clk),
    .rst     (rst),
    .wr      (wr_i),
    .wr_data (wr_data_i),
    .load    (load),
    .irq_ack (irq_ack_i),
    .irq_clr (irq_clr_i),
    .held    (held),
    .empty   (buf_empty_o),
    .irq     (irq_o)
  );

  sertx_framer u_frm (
    .clk       (clk),
    .rst       (rst),
    .bit_tick  (bit_tick),
    .start_ok  (start_ok),
    .frm       (frm),
    .load      (load),
    .txd       (txd_o),
    .reg_empty (reg_empty_o)
  );

endmodule

// File: rtl/sertx_dbuf_chk.sv
module sertx_dbuf_chk (
  input logic clk,
  input logic rst,
  input logic tx_en_i,
  input logic wr_i,
  input logic irq_ack_i,
  input logic irq_clr_i,
  input logic txd_o,
  input logic buf_empty_o,
  input logic reg_empty_o,
  input logic irq_o
);

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    reg_empty_o |-> txd_o);  // R11

  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> !buf_empty_o);  // R5

  AST_START_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
    ($fell(txd_o) && $past(reg_empty_o)) |-> (irq_o && !reg_empty_o));  // R6

  AST_START_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    ($fell(txd_o) && $past(reg_empty_o)) |-> ($past(tx_en_i) && !$past(buf_empty_o)));  // R8

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !irq_ack_i && !irq_clr_i) |=> irq_o);  // R10

endmodule

bind sertx_dbuf sertx_dbuf_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .tx_en_i     (tx_en_i),
  .wr_i        (wr_i),
  .irq_ack_i   (irq_ack_i),
  .irq_clr_i   (irq_clr_i),
  .txd_o       (txd_o),
  .buf_empty_o (buf_empty_o),
  .reg_empty_o (reg_empty_o),
  .irq_o       (irq_o)
);

// File: tb/sertx_dbuf_test.sv
module sertx_dbuf_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_clk = 1'b0;
  bit         ext_run = 1'b0;
  logic [2:0] src_sel = 3'd0;
  logic [7:0] div = 8'd0;
  logic       tx_en = 1'b0, len9 = 1'b0, par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0;
  logic       cts_sel = 1'b0, cts_n = 1'b1;
  logic       wr = 1'b0;
  logic [8:0] wr_data = 9'd0;
  logic       irq_ack = 1'b0, irq_clr = 1'b0;
  logic       txd, buf_empty, reg_empty, irq;

  int total = 0;
  int bad   = 0;
  bit expq[$];

  sertx_dbuf uut (
    .clk (clk), .rst (rst), .ext_clk_i (ext_clk), .src_sel_i (src_sel), .div_i (div),
    .tx_en_i (tx_en), .len9_i (len9), .par_en_i (par_en), .par_odd_i (par_odd),
    .stop2_i (stop2), .cts_sel_i (cts_sel), .cts_n_i (cts_n), .wr_i (wr),
    .wr_data_i (wr_data), .irq_ack_i (irq_ack), .irq_clr_i (irq_clr),
    .txd_o (txd), .buf_empty_o (buf_empty), .reg_empty_o (reg_empty), .irq_o (irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(2*CLK_PERIOD) if (ext_run) ext_clk = ~ext_clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // expected line bits, first bit first
  task automatic build_expect(input logic [8:0] d, input logic l9, input logic pe,
                              input logic odd, input logic s2);
    logic [8:0] tmp = d;
    bit p = 1'b0;
    int nd = l9 ? 9 : 8;
    expq.delete();
    expq.push_back(1'b0);
    for (int i = 0; i < nd; i++) begin
      expq.push_back(tmp[0]);
      p   = p ^ tmp[0];
      tmp = tmp >> 1;
    end
    if (pe) expq.push_back(p ^ odd);
    expq.push_back(1'b1);
    if (s2) expq.push_back(1'b1);
  endtask

  task automatic write_word(input logic [8:0] d);
    @(negedge clk);
    wr      = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr      = 1'b0;
  endtask

  task automatic wait_start(input int limit, output int waited);
    waited = -1;
    for (int c = 0; c < limit; c++) begin
      @(negedge clk);
      if (txd == 1'b0) begin
        waited = c;
        break;
      end
    end
  endtask

  // called at the negedge where the start bit was first seen; ends mid last stop bit
  task automatic rx_body(input string tag, input int per);
    for (int k = 0; k < expq.size(); k++) begin
      repeat ((k == 0) ? per/2 : per) @(negedge clk);
      chk(tag, int'(txd), int'(expq[k]));
    end
  endtask

  task automatic send_and_check(input string tag, input logic [8:0] d, input int per);
    int w;
    build_expect(d, len9, par_en, par_odd, stop2);
    write_word(d);
    wait_start(4*per, w);
    chk({tag, " start seen"}, int'(w >= 0), 1);
    if (w >= 0) rx_body(tag, per);
  endtask

  task automatic count_lows(input int cycles, output int lows);
    lows = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (txd == 1'b0) lows++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R4..R11 act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w, lows, per;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R4 txd", int'(txd), 1);
    chk("R4 buf_empty", int'(buf_empty), 1);
    chk("R4 reg_empty", int'(reg_empty), 1);
    chk("R4 irq", int'(irq), 0);

    // first frame, 8N1, clock/2, n=0
    tx_en = 1'b1;
    per   = 32;
    build_expect(9'h0A5, 1'b0, 1'b0, 1'b0, 1'b0);
    write_word(9'h0A5);
    chk("R5 buf_empty after write", int'(buf_empty), 0);
    wait_start(4*per, w);
    chk("R6 start seen", int'(w >= 0), 1);
    chk("R6 irq at start", int'(irq), 1);
    chk("R6 buf_empty at start", int'(buf_empty), 1);
    chk("R11 reg_empty low in frame", int'(reg_empty), 0);
    rx_body("R3 R1 frame 0xA5", per);
    repeat (per) @(negedge clk);
    chk("R11 reg_empty after frame", int'(reg_empty), 1);
    chk("R11 txd idle", int'(txd), 1);
    chk("R10 irq held", int'(irq), 1);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    chk("R10 irq after ack", int'(irq), 0);

    // overwrite while held with transmit disabled
    tx_en = 1'b0;
    write_word(9'h011);
    write_word(9'h03C);
    count_lows(3*per, lows);
    chk("R8 no frame while disabled", lows, 0);
    chk("R8 buf_empty stays 0", int'(buf_empty), 0);
    build_expect(9'h03C, 1'b0, 1'b0, 1'b0, 1'b0);
    tx_en = 1'b1;
    wait_start(4*per, w);
    chk("R5 start after enable", int'(w >= 0), 1);
    if (w >= 0) rx_body("R5 replaced word sent", per);
    repeat (per) @(negedge clk);

    // back-to-back frames
    par_en = 1'b1;
    build_expect(9'h0F0, 1'b0, 1'b1, 1'b0, 1'b0);
    write_word(9'h0F0);
    wait_start(4*per, w);
    write_word(9'h00F);
    rx_body("R3 b2b first", per);
    build_expect(9'h00F, 1'b0, 1'b1, 1'b0, 1'b0);
    wait_start(per, w);
    chk("R7 no gap between frames", int'(w >= 0 && w <= per/2 + 1), 1);
    if (w >= 0) rx_body("R7 b2b second", per);
    repeat (per) @(negedge clk);

    // disable during a frame with the next word held
    par_en = 1'b0;
    build_expect(9'h055, 1'b0, 1'b0, 1'b0, 1'b0);
    write_word(9'h055);
    wait_start(4*per, w);
    write_word(9'h0AA);
    tx_en = 1'b0;
    rx_body("R8 frame completes", per);
    count_lows(4*per, lows);
    chk("R8 no next frame", lows, 0);
    chk("R8 reg_empty", int'(reg_empty), 1);
    chk("R8 buf_empty held", int'(buf_empty), 0);
    build_expect(9'h0AA, 1'b0, 1'b0, 1'b0, 1'b0);
    tx_en = 1'b1;
    wait_start(4*per, w);
    chk("R8 resumes", int'(w >= 0), 1);
    if (w >= 0) rx_body("R8 held word", per);
    repeat (per) @(negedge clk);

    // clear-to-send gating
    cts_sel = 1'b1;
    cts_n   = 1'b1;
    write_word(9'h0C3);
    count_lows(4*per, lows);
    chk("R9 blocked by cts high", lows, 0);
    chk("R9 word held", int'(buf_empty), 0);
    build_expect(9'h0C3, 1'b0, 1'b0, 1'b0, 1'b0);
    cts_n = 1'b0;
    wait_start(4*per, w);
    chk("R9 starts on cts low", int'(w >= 0), 1);
    if (w >= 0) rx_body("R9 frame", per);
    repeat (per) @(negedge clk);
    chk("R10 irq set before clr", int'(irq), 1);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk("R10 irq after clr", int'(irq), 0);
    cts_sel = 1'b0;
    cts_n   = 1'b1;
    send_and_check("R9 cts ignored when not selected", 9'h081, per);
    repeat (per) @(negedge clk);

    // random frame formats
    for (int r = 0; r < 30; r++) begin
      @(negedge clk);
      div     = 8'($urandom_range(0, 1));
      len9    = 1'($urandom_range(0, 1));
      par_en  = 1'($urandom_range(0, 1));
      par_odd = 1'($urandom_range(0, 1));
      stop2   = 1'($urandom_range(0, 1));
      per     = 32 * (int'(div) + 1);
      send_and_check("R3 R1 random frame", 9'($urandom), per);
      repeat (per) @(negedge clk);
    end

    // external tick source: 4 clocks per edge, n=0
    @(negedge clk);
    div = 8'd0; len9 = 1'b1; par_en = 1'b1; par_odd = 1'b1; stop2 = 1'b1;
    ext_run = 1'b1;
    src_sel = 3'd4;
    send_and_check("R2 external source", 9'h1B4, 64);
    repeat (64) @(negedge clk);

    // clock/16 and clock/64 taps
    ext_run = 1'b0;
    len9 = 1'b0; par_en = 1'b0; stop2 = 1'b0;
    src_sel = 3'd1;
    send_and_check("R2 clock/16 source", 9'h036, 256);
    repeat (256) @(negedge clk);
    src_sel = 3'd2;
    send_and_check("R2 clock/64 source", 9'h0C9, 1024);
    repeat (1024) @(negedge clk);

    // clock/512 tap: start bit and first data bit only
    src_sel = 3'd3;
    write_word(9'h001);
    wait_start(4*8192, w);
    chk("R2 clock/512 start seen", int'(w >= 0), 1);
    repeat (4096) @(negedge clk);
    chk("R2 clock/512 start mid", int'(txd), 0);
    repeat (8192) @(negedge clk);
    chk("R2 clock/512 bit0 mid", int'(txd), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule